// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory Wrapper

This block is a small on-chip memory that keeps every 64 data bits together with 8 check bits in one 72-bit code word. Requesters see a 32-bit port with byte enables, so each code word holds two neighbouring bus words. Every access checks the addressed code word. A single flipped bit is repaired in the data handed back, and the stored word stays as it is. A double flip is reported and the data is returned as found.

Writes are always narrower than a code word, so each write is a read-modify-write done in one clock. The stored word is read and corrected where possible. The enabled bytes are merged in, fresh check bits are computed, and the result is written back. Because of this, a write to a word with a single fault also repairs it.

Three sticky flags record single errors, double errors seen on reads, and double errors seen during writes. Writing ones clears them. The code-word address of the first error after a clear is held alongside the flags. An injection input XORs a chosen mask into one stored code word, so that every fault case can be produced on purpose.

Top module: `secded_sram`

## Requirements
- R1: A read request (req_valid high, req_write low) gives rsp_valid high exactly one cycle later. rsp_rdata is then the lower 32 bits of the code word when req_addr[0] is 0, and the upper 32 bits when it is 1. A write or an idle cycle gives rsp_valid low one cycle later.
- R2: Stored code word layout. Bit 0 is the overall parity of all 72 bits. Bits 1 to 71 are Hamming positions, with check bits at positions 1, 2, 4, 8, 16, 32 and 64. Data bit j sits at the j-th non-power-of-two position in ascending order, so position p holds data bit p - floor(log2 p) - 2.
- R3: When exactly one of the 72 stored bits is wrong, a read returns the correct data and err_flags[0] is set in the same cycle as rsp_valid.
- R4: When exactly two stored bits are wrong, a read sets err_flags[1] and returns the stored data bits uncorrected.
- R5: A fault in a code word is reported whichever of its two 32-bit halves is read.
- R6: Correction on a read never changes the array. Reading the same faulty word again after the flags are cleared sets the flag again.
- R7: While clr_valid is high, every err_flags bit whose clr_bits bit is 1 is cleared at the next edge. The other bits stay set. A new error in the same cycle as a clear leaves its flag set.
- R8: err_addr takes the code-word address (req_addr[ADDR_W-1:1]) of an error that arrives while no flag would remain set. It holds that value while any flag stays set. It is 0 after reset.
- R9: A write replaces only the bytes selected by req_be in the addressed half. It keeps the other bytes and the other half, taking them from the corrected word. It leaves a clean code word, so a later single flip in that word is again correctable.
- R10: A write whose read finds a double error is still carried out. It merges into the uncorrected data and sets err_flags[2], not err_flags[1].
- R11: A write whose read finds a single error sets err_flags[0].
- R12: inj_en XORs inj_mask into the stored code word at inj_addr at the clock edge and produces no response.
- R13: After reset, rsp_valid, rsp_rdata, err_flags and err_addr are all 0, and every stored word reads as clean zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | 32-bit word address; bit 0 picks the half of a code word |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data, corrected when possible |
| inj_en | input | 1 | Apply a fault mask this cycle |
| inj_addr | input | ADDR_W-1 | Code-word address for the fault mask |
| inj_mask | input | 72 | Bits of the stored code word to flip |
| clr_valid | input | 1 | Write-one-to-clear strobe for the flags |
| clr_bits | input | 3 | Flags to clear (bit 0 single, bit 1 read double, bit 2 write double) |
| err_flags | output | 3 | Sticky flags: bit 0 single, bit 1 double on read, bit 2 double during a write |
| err_addr | output | ADDR_W-1 | Code-word address of the first error since the flags were cleared |

## Verification
A wrong syndrome or a misplaced data bit shows up in rsp_rdata one cycle after the read. With a single fault the returned data is wrong, and with a double fault the pattern of corrupted bits differs from the one the layout predicts. A wrong merge or a stale code word after a write shows on the next read of either half. A later read then also carries a spurious flag. Flag and address state errors appear on err_flags and err_addr in the cycle after the event or clear that should have changed them. The bench sweeps every single-bit and every adjacent-pair fault across the 72 bits and all sixteen byte-enable patterns.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DW = 64;
  localparam int CW = 72;
  localparam int SW = 7;

  typedef logic [CW-1:0] cword_t;
  typedef logic [DW-1:0] dword_t;

  function automatic logic is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // XOR of the positions of all set bits among Hamming positions 1..CW-1
  function automatic logic [SW-1:0] ecc_syndrome(input cword_t c);
    logic [SW-1:0] s;
    s = '0;
    for (int p = 1; p < CW; p++)
      if (c[p]) s ^= SW'(p);
    return s;
  endfunction

  function automatic cword_t ecc_encode(input dword_t d);
    cword_t c;
    logic [SW-1:0] s;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < CW; p++)
      if (!is_pow2(p)) begin
        c[p] = d[j];
        j++;
      end
    s = ecc_syndrome(c);
    for (int k = 0; k < SW; k++) c[1 << k] = s[k];
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic dword_t ecc_extract(input cword_t c);
    dword_t d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p < CW; p++)
      if (!is_pow2(p)) begin
        d[j] = c[p];
        j++;
      end
    return d;
  endfunction

  function automatic dword_t byte_merge(input dword_t base, input logic hi,
                                        input logic [31:0] wd, input logic [3:0] be);
    logic [31:0] h;
    h = hi ? base[63:32] : base[31:0];
    for (int b = 0; b < 4; b++)
      if (be[b]) h[8*b +: 8] = wd[8*b +: 8];
    return hi ? {h, base[31:0]} : {base[63:32], h};
  endfunction
endpackage

// File: rtl/secded_store.sv
module secded_store import secded_pkg::*; #(
  parameter int LA = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [LA-1:0] waddr,
  input  cword_t        wdata,
  input  logic          inj_en,
  input  logic [LA-1:0] inj_addr,
  input  cword_t        inj_mask,
  input  logic [LA-1:0] raddr,
  output cword_t        rdata
);
  localparam int N = 1 << LA;

  cword_t mem [N];

  for (genvar g = 0; g < N; g++) begin : g_row
    logic hit_w, hit_i;
    assign hit_w = we && (waddr == LA'(g));
    assign hit_i = inj_en && (inj_addr == LA'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) mem[g] <= '0;
      else if (hit_w || hit_i)
        mem[g] <= (hit_w ? wdata : mem[g]) ^ (hit_i ? inj_mask : '0);
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/secded_decode.sv
module secded_decode import secded_pkg::*; (
  input  cword_t cw_i,
  output dword_t data_o,
  output logic   single_o,
  output logic   double_o
);
  localparam logic [SW-1:0] SYN_MAX = SW'(CW - 1);

  logic [SW-1:0] syn;
  logic          par;
  cword_t        fixed;

  always_comb begin
    syn      = ecc_syndrome(cw_i);
    par      = ^cw_i;
    single_o = par && (syn <= SYN_MAX);
    double_o = (!par && syn != '0) || (par && syn > SYN_MAX);
    fixed    = cw_i ^ (single_o ? (cword_t'(1) << syn) : '0);
    data_o   = ecc_extract(fixed);
  end
endmodule

// File: rtl/secded_status.sv
module secded_status #(
  parameter int LA = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    ev,
  input  logic [LA-1:0] ev_addr,
  input  logic          clr_valid,
  input  logic [2:0]    clr_bits,
  output logic [2:0]    flags_o,
  output logic [LA-1:0] addr_o
);
  logic [2:0]    flags_q;
  logic [LA-1:0] addr_q;
  logic [2:0]    kept;

  assign kept = flags_q & ~(clr_valid ? clr_bits : 3'b000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      addr_q  <= '0;
    end else begin
      flags_q <= kept | ev;
      if (kept == '0 && ev != '0) addr_q <= ev_addr;
    end
  end

  assign flags_o = flags_q;
  assign addr_o  = addr_q;

  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != '0 && !clr_valid) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != '0 && !clr_valid) |=> $stable(addr_q));
endmodule

// File: rtl/secded_sram.sv
module secded_sram import secded_pkg::*; #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              inj_en,
  input  logic [ADDR_W-2:0] inj_addr,
  input  logic [CW-1:0]     inj_mask,
  input  logic              clr_valid,
  input  logic [2:0]        clr_bits,
  output logic [2:0]        err_flags,
  output logic [ADDR_W-2:0] err_addr
);
  localparam int LA = ADDR_W - 1;

  logic [LA-1:0] cw_addr;
  logic          half_hi;
  cword_t        cw_rd, cw_wr;
  dword_t        dec_data;
  logic          ev_single, ev_double;
  logic          rd_go, wr_go;
  logic          ev_any_single, ev_rd_double, ev_wr_double;

  assign cw_addr = req_addr[ADDR_W-1:1];
  assign half_hi = req_addr[0];
  assign rd_go   = req_valid && !req_write;
  assign wr_go   = req_valid && req_write;

  secded_store #(.LA(LA)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(wr_go), .waddr(cw_addr), .wdata(cw_wr),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask),
    .raddr(cw_addr), .rdata(cw_rd)
  );

  secded_decode u_decode (
    .cw_i(cw_rd), .data_o(dec_data), .single_o(ev_single), .double_o(ev_double)
  );

  assign cw_wr = ecc_encode(byte_merge(dec_data, half_hi, req_wdata, req_be));

  assign ev_any_single = req_valid && ev_single;
  assign ev_rd_double  = rd_go && ev_double;
  assign ev_wr_double  = wr_go && ev_double;

  secded_status #(.LA(LA)) u_status (
    .clk(clk), .rst_n(rst_n),
    .ev({ev_wr_double, ev_rd_double, ev_any_single}), .ev_addr(cw_addr),
    .clr_valid(clr_valid), .clr_bits(clr_bits),
    .flags_o(err_flags), .addr_o(err_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_rdata <= half_hi ? dec_data[63:32] : dec_data[31:0];
    end
  end

  assert_rsp_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rsp_valid);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> !rsp_valid);
  assert_read_single_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && ev_single) |=> err_flags[0]);
  assert_read_double_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_double |=> err_flags[1]);
  assert_write_double_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_double |=> err_flags[2]);
  assert_one_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_single && ev_double));
endmodule

// File: tb/secded_sram_bench.sv
module secded_sram_bench;
  localparam int AW  = 5;
  localparam int NCW = 1 << (AW - 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [3:0]    req_be = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          inj_en = 1'b0;
  logic [AW-2:0] inj_addr = '0;
  logic [71:0]   inj_mask = '0;
  logic          clr_valid = 1'b0;
  logic [2:0]    clr_bits = '0;
  logic [2:0]    err_flags;
  logic [AW-2:0] err_addr;

  secded_sram #(.ADDR_W(AW)) u_secded_sram (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask),
    .clr_valid(clr_valid), .clr_bits(clr_bits),
    .err_flags(err_flags), .err_addr(err_addr)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [63:0] model  [NCW];
  logic [71:0] shadow [NCW];

  function automatic int flog2(int p);
    int r = 0;
    while ((p >> (r + 1)) != 0) r++;
    return r;
  endfunction

  // data bits hit by a stored-bit mask, from the layout rule of R2
  function automatic logic [63:0] dmask(logic [71:0] m);
    logic [63:0] r = '0;
    for (int p = 3; p < 72; p++)
      if ((p & (p - 1)) != 0 && m[p]) r[p - flog2(p) - 2] = 1'b1;
    return r;
  endfunction

  function automatic logic [63:0] seen(int c);
    return ($countones(shadow[c]) >= 2) ? (model[c] ^ dmask(shadow[c])) : model[c];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(int a, logic [2:0] ef, string req);
    logic [63:0] w = seen(a >> 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    check({req, " data"}, 64'(rsp_rdata), 64'((a & 1) ? w[63:32] : w[31:0]));
    check({req, " flags"}, 64'(err_flags), 64'(ef));
  endtask

  task automatic do_write(int a, logic [31:0] d, logic [3:0] be, logic [2:0] ef, string req);
    int c = a >> 1;
    logic [63:0] base = seen(c);
    logic [31:0] h = (a & 1) ? base[63:32] : base[31:0];
    for (int b = 0; b < 4; b++) if (be[b]) h[8*b +: 8] = d[8*b +: 8];
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model[c]  = (a & 1) ? {h, base[31:0]} : {base[63:32], h};
    shadow[c] = '0;
    check({req, " write rsp_valid"}, 64'(rsp_valid), 64'd0);
    check({req, " write flags"}, 64'(err_flags), 64'(ef));
  endtask

  task automatic inject(int c, logic [71:0] m);
    inj_en = 1'b1; inj_addr = (AW-1)'(c); inj_mask = m;
    @(negedge clk);
    inj_en = 1'b0;
    shadow[c] ^= m;
    check("R12 no response on inject", 64'(rsp_valid), 64'd0);
  endtask

  task automatic clear(logic [2:0] b);
    clr_valid = 1'b1; clr_bits = b;
    @(negedge clk);
    clr_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCW; c++) begin model[c] = '0; shadow[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 rsp_valid", 64'(rsp_valid), 0);
    check("R13 rsp_rdata", 64'(rsp_rdata), 0);
    check("R13 flags", 64'(err_flags), 0);
    check("R13 err_addr", 64'(err_addr), 0);
    for (int a = 0; a < 2*NCW; a++) do_read(a, 3'b000, "R13 clean zero");

    // R1 R9: full writes of every word, then read back
    for (int a = 0; a < 2*NCW; a++)
      do_write(a, 32'h9E37_79B9 * (a + 1) ^ 32'h0F0F_5A5A, 4'hF, 3'b000, "R9 full");
    for (int a = 0; a < 2*NCW; a++) do_read(a, 3'b000, "R1 readback");
    @(negedge clk);
    check("R1 idle no rsp", 64'(rsp_valid), 0);

    // R3 R5 R8: every single-bit fault, both halves
    for (int b = 0; b < 72; b++) begin
      inject(5, 72'(1) << b);
      do_read(10, 3'b001, "R3 single lo");
      if (b == 0) check("R8 first addr", 64'(err_addr), 64'd5);
      do_read(11, 3'b001, "R5 single hi");
      clear(3'b111);
      check("R7 cleared", 64'(err_flags), 0);
      inject(5, 72'(1) << b);
    end

    // R2 R4 R5: every adjacent pair of stored bits
    for (int b = 0; b < 72; b++) begin
      inject(6, (72'(1) << b) | (72'(1) << ((b + 1) % 72)));
      do_read(12, 3'b010, "R4 double lo");
      do_read(13, 3'b010, "R2 R5 double hi");
      clear(3'b111);
      inject(6, (72'(1) << b) | (72'(1) << ((b + 1) % 72)));
    end

    // R6 R8: array not repaired by a read; address held
    inject(7, 72'(1) << 40);
    do_read(14, 3'b001, "R6 first read");
    clear(3'b001);
    do_read(15, 3'b001, "R6 re-read still faulty");
    inject(3, 72'h30);
    do_read(6, 3'b011, "R8 second error");
    check("R8 addr held", 64'(err_addr), 64'd7);
    clear(3'b001);
    check("R7 partial clear", 64'(err_flags), 64'd2);
    check("R8 addr held partial", 64'(err_addr), 64'd7);
    clear(3'b010);
    do_read(7, 3'b010, "R8 new first error");
    check("R8 new addr", 64'(err_addr), 64'd3);

    // R7: clear in same cycle as a new error
    clr_valid = 1'b1; clr_bits = 3'b111;
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(14);
    @(negedge clk);
    clr_valid = 1'b0; req_valid = 1'b0;
    check("R7 set wins", 64'(err_flags), 64'd1);
    check("R8 addr after clear+event", 64'(err_addr), 64'd7);
    clear(3'b111);

    // R9 R11: write over a single fault repairs the word
    inject(9, 72'(1) << 20);
    do_write(18, 32'hCAFE_F00D, 4'b0101, 3'b001, "R11 rmw single");
    clear(3'b111);
    do_read(18, 3'b000, "R9 merged lo clean");
    do_read(19, 3'b000, "R9 other half clean");
    inject(9, 72'(1) << 55);
    do_read(19, 3'b001, "R9 later single correctable");
    clear(3'b111);
    inject(9, 72'(1) << 55);

    // R10: write over a double fault
    inject(10, 72'h600);
    do_write(20, 32'h1234_5678, 4'hF, 3'b100, "R10 rmw double");
    do_read(21, 3'b100, "R10 raw half kept, now clean");
    clear(3'b111);

    // R9: every byte-enable pattern
    for (int be = 0; be < 16; be++) begin
      do_write(24 + (be & 1), 32'h1111_1111 * (be + 1), 4'(be), 3'b000, "R9 byte enables");
      do_read(24, 3'b000, "R9 be lo");
      do_read(25, 3'b000, "R9 be hi");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule